// File: doc/BRIEF.md
# Double-Buffered Channel Correction Registers

This block keeps the gain and offset correction settings for three conversion channels, A, B and C. The settings arrive one channel at a time over a shared 15-bit word bus. Each channel has its own active-low load strobe. When a channel's strobe falls, that channel's staging register takes the word on the bus.

A separate cycle strobe controls the output stage. When it rises, all three staging registers are copied into the output registers on the same system clock edge. The gain and offset codes for the three channels therefore change together. The settings for the next sample can then be staged while the current sample is in use.

All four strobes are asynchronous inputs. The block synchronises them into the system clock domain and detects their edges there, so none of them acts as a clock.

Top module: `corr_regs_top`

## Requirements
- R1: The correction word is split into two fields. Bits 14..6 form the 9-bit gain code, with bit 14 as its MSB. Bits 5..0 form the 6-bit offset code, with bit 5 as its MSB. Channel c occupies slice c of each packed output, where c is 0 for A, 1 for B and 2 for C.
- R2: A falling edge on a channel's load strobe (`ld_n_i` bit c) captures the bus into that channel's staging register only. The staging registers of the other channels keep their contents.
- R3: Holding a load strobe low loads the bus only once. Bus changes made while the strobe stays low, or at its rising edge, are not captured.
- R4: Loading a staging register does not change the outputs. The outputs keep their previous values until the next rising edge of the cycle strobe.
- R5: A rising edge of `cyc_i` copies all three staging registers to the outputs in the same system clock cycle.
- R6: A falling edge of `cyc_i` changes no output and raises no update pulse.
- R7: Each transfer into a channel's output register raises that channel's `upd_o` bit for exactly one system clock cycle.
- R8: A synchronous active-low reset clears both register stages to zero. After reset, a transfer with no loads drives all codes to zero.
- R9: The power-up sequence works. With `cyc_i` held high, the A, B and C strobes are each pulsed low and then high with their own data on the bus. A later low-then-high cycle of `cyc_i` then presents those three words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| corr_bus_i | input | 15 | Shared correction word bus |
| cyc_i | input | 1 | Cycle strobe; rising edge transfers all channels |
| ld_n_i | input | 3 | Per-channel load strobes, active low; bit 0 is A |
| gain_o | output | 27 | Gain codes, 9 bits per channel, A in the low slice |
| offs_o | output | 18 | Offset codes, 6 bits per channel, A in the low slice |
| upd_o | output | 3 | One-cycle pulse per channel when its output reloads |

## Verification
The hardest case to bring about is the gap between staging and transfer. A staging register holds a new word, but the outputs must still show the previous cycle's words. In that gap, a bus change during a held-low strobe must stay invisible.

Every bench cycle reaches this state. While each strobe is still low, the bench drives the complemented word onto the bus. Before raising `cyc_i`, it checks that the outputs still hold the previous values. Separate sequences cover the power-up order with the cycle strobe held high, a falling cycle strobe after staging, and a transfer straight after a mid-run reset.

// File: rtl/corr_pkg.sv
// Package: shared defaults for the correction register block.
// Assumes the word is laid out as gain in the upper field and offset in the lower field.
package corr_pkg;
    localparam int GAIN_W_DEF = 9;
    localparam int OFFS_W_DEF = 6;
    localparam int NCH_DEF    = 3;
    localparam int SYNC_DEF   = 2;
endpackage

// File: rtl/corr_edge_det.sv
// Module: synchronises an asynchronous strobe and emits a one-cycle pulse on one chosen edge.
// Assumes SYNC >= 2. IDLE is the level the strobe rests at after reset.
module corr_edge_det #(
    parameter int SYNC        = corr_pkg::SYNC_DEF,
    parameter bit IDLE        = 1'b1,
    parameter bit DETECT_RISE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;

    // Shift the raw strobe through the synchroniser and keep the previous settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC{IDLE}};
            prev_q <= IDLE;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], sig_i};
            prev_q <= sync_q[SYNC-1];
        end
    end

    // Pick the requested edge polarity.
    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_o = sync_q[SYNC-1] & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sync_q[SYNC-1] & prev_q;
        end
    endgenerate

    // R3: a held level produces at most one pulse.
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/corr_stage1.sv
// Module: one channel's staging register; takes the aligned bus word on a load pulse.
// Assumes load_i comes from the edge detector, aligned with word_i.
module corr_stage1 #(
    parameter int W = corr_pkg::GAIN_W_DEF + corr_pkg::OFFS_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);
    // Capture the bus word on this channel's load pulse only.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_o <= '0;
        else if (load_i) word_o <= word_i;
    end

    // R2: the staged word changes only after this channel's own load pulse.
    assert_stage_own_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o != $past(word_o)) |-> $past(load_i));
endmodule

// File: rtl/corr_stage2.sv
// Module: output register bank; copies every staged word on a transfer pulse and
// splits each word into its gain and offset fields.
// Assumes xfer_i is a one-cycle pulse.
module corr_stage2 #(
    parameter int NCH    = corr_pkg::NCH_DEF,
    parameter int GAIN_W = corr_pkg::GAIN_W_DEF,
    parameter int OFFS_W = corr_pkg::OFFS_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xfer_i,
    input  logic [NCH*(GAIN_W+OFFS_W)-1:0] staged_i,
    output logic [NCH*GAIN_W-1:0]   gain_o,
    output logic [NCH*OFFS_W-1:0]   offs_o,
    output logic [NCH-1:0]          upd_o
);
    localparam int W = GAIN_W + OFFS_W;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            // Copy one channel on the shared transfer pulse and flag the load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    gain_o[c*GAIN_W +: GAIN_W] <= '0;
                    offs_o[c*OFFS_W +: OFFS_W] <= '0;
                    upd_o[c]                   <= 1'b0;
                end else begin
                    upd_o[c] <= xfer_i;
                    if (xfer_i) begin
                        gain_o[c*GAIN_W +: GAIN_W] <= staged_i[c*W+OFFS_W +: GAIN_W];
                        offs_o[c*OFFS_W +: OFFS_W] <= staged_i[c*W +: OFFS_W];
                    end
                end
            end

            // R1: after a load, the gain field equals the upper part of the staged word.
            assert_gain_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
                upd_o[c] |-> gain_o[c*GAIN_W +: GAIN_W] == $past(staged_i[c*W+OFFS_W +: GAIN_W]));

            // R4: the outputs move only in a cycle flagged as an update.
            assert_out_only_on_upd_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (offs_o[c*OFFS_W +: OFFS_W] != $past(offs_o[c*OFFS_W +: OFFS_W])) |-> upd_o[c]);

            // R7: each update flag lasts a single cycle.
            assert_upd_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
                upd_o[c] |=> !upd_o[c]);
        end
    endgenerate

    // R5: either every channel updates or none does.
    assert_all_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(upd_o) == 0) || ($countones(upd_o) == NCH));
endmodule

// File: rtl/corr_regs_top.sv
// Module: top of the double-buffered correction registers. It synchronises the
// strobes, aligns the bus with them, stages each channel and transfers all channels together.
// Assumes the strobes and the bus are asynchronous and each is held for several clocks.
module corr_regs_top #(
    parameter int NCH    = corr_pkg::NCH_DEF,
    parameter int GAIN_W = corr_pkg::GAIN_W_DEF,
    parameter int OFFS_W = corr_pkg::OFFS_W_DEF,
    parameter int SYNC   = corr_pkg::SYNC_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [GAIN_W+OFFS_W-1:0] corr_bus_i,
    input  logic                     cyc_i,
    input  logic [NCH-1:0]           ld_n_i,
    output logic [NCH*GAIN_W-1:0]    gain_o,
    output logic [NCH*OFFS_W-1:0]    offs_o,
    output logic [NCH-1:0]           upd_o
);
    localparam int W = GAIN_W + OFFS_W;

    logic [W-1:0]     bus_pipe [SYNC];
    logic [NCH-1:0]   load_p;
    logic             xfer_p;
    logic [NCH*W-1:0] staged;

    // Delay the bus by the synchroniser depth so it lines up with the detected edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) bus_pipe[i] <= '0;
        end else begin
            bus_pipe[0] <= corr_bus_i;
            for (int i = 1; i < SYNC; i++) bus_pipe[i] <= bus_pipe[i-1];
        end
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            corr_edge_det #(.SYNC(SYNC), .IDLE(1'b1), .DETECT_RISE(1'b0)) u_ld_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .sig_i (ld_n_i[c]),
                .edge_o(load_p[c])
            );
            corr_stage1 #(.W(W)) u_stage1 (
                .clk   (clk),
                .rst_n (rst_n),
                .load_i(load_p[c]),
                .word_i(bus_pipe[SYNC-1]),
                .word_o(staged[c*W +: W])
            );
        end
    endgenerate

    corr_edge_det #(.SYNC(SYNC), .IDLE(1'b1), .DETECT_RISE(1'b1)) u_cyc_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (cyc_i),
        .edge_o(xfer_p)
    );

    corr_stage2 #(.NCH(NCH), .GAIN_W(GAIN_W), .OFFS_W(OFFS_W)) u_stage2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer_i  (xfer_p),
        .staged_i(staged),
        .gain_o  (gain_o),
        .offs_o  (offs_o),
        .upd_o   (upd_o)
    );

    // R6: an update follows only a transfer pulse, and a falling cycle strobe never makes one.
    assert_upd_needs_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o[0] |-> $past(xfer_p));
endmodule

// File: tb/tb_corr_regs_top.sv
// Bench: drives whole conversion cycles over a sweep of computed words and checks
// the fields, the staging isolation and the update pulses at the ports.
module tb_corr_regs_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  NCH = 3;
    localparam int  GW  = 9;
    localparam int  OW  = 6;
    localparam int  W   = GW + OW;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [W-1:0]       bus = '0;
    logic               cyc = 1'b1;
    logic [NCH-1:0]     ld_n = '1;
    logic [NCH*GW-1:0]  gain;
    logic [NCH*OW-1:0]  offs;
    logic [NCH-1:0]     upd;

    int n_chk = 0;
    int n_bad = 0;
    int upd_cnt [NCH];
    int all_cnt = 0;
    logic [W-1:0] cur_w [NCH];

    corr_regs_top dut (
        .clk(clk), .rst_n(rst_n), .corr_bus_i(bus), .cyc_i(cyc),
        .ld_n_i(ld_n), .gain_o(gain), .offs_o(offs), .upd_o(upd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count update pulses away from the active edge.
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) if (upd[c]) upd_cnt[c] += 1;
        if (upd == '1) all_cnt += 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_cnt();
        for (int c = 0; c < NCH; c++) upd_cnt[c] = 0;
        all_cnt = 0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Check every channel's outputs against the expected words (R1 field split).
    task automatic chk_out(input logic [W-1:0] w [NCH], input string req);
        for (int c = 0; c < NCH; c++) begin
            chk(gain[c*GW +: GW] == w[c][14:6], req, gain[c*GW +: GW], w[c][14:6]);
            chk(offs[c*OW +: OW] == w[c][5:0],  req, offs[c*OW +: OW], w[c][5:0]);
        end
    endtask

    // Pulse one channel's strobe; the complemented word is driven while low (R3).
    task automatic load_ch(input int c, input logic [W-1:0] w);
        bus = w;
        tick(2);
        ld_n[c] = 1'b0;
        tick(4);
        bus = ~w;
        tick(4);
        ld_n[c] = 1'b1;
        tick(4);
        bus = w ^ 15'h2AAA;
        tick(2);
    endtask

    // One normal cycle: cyc low, stage A, B, C, check isolation, cyc high, check.
    task automatic run_cycle(input logic [W-1:0] w [NCH]);
        cyc = 1'b0;
        tick(5);
        for (int c = 0; c < NCH; c++) load_ch(c, w[c]);
        chk_out(cur_w, "R4");
        clr_cnt();
        cyc = 1'b1;
        tick(6);
        chk_out(w, "R1/R2/R3/R5");
        for (int c = 0; c < NCH; c++) chk(upd_cnt[c] == 1, "R7", upd_cnt[c], 1);
        chk(all_cnt == 1, "R5", all_cnt, 1);
        cur_w = w;
    endtask

    initial begin
        logic [W-1:0] w [NCH];
        for (int c = 0; c < NCH; c++) cur_w[c] = '0;
        clr_cnt();
        tick(4);
        chk_out(cur_w, "R8");
        chk(upd == '0, "R8", upd, 0);
        rst_n = 1'b1;
        tick(4);

        // R9: power-up order with cyc held high, then R6: a falling cyc changes nothing.
        w[0] = 15'h7FFF; w[1] = 15'h0000; w[2] = 15'h4041;
        for (int c = 0; c < NCH; c++) load_ch(c, w[c]);
        clr_cnt();
        cyc = 1'b0;
        tick(8);
        chk_out(cur_w, "R6");
        chk(upd_cnt[0] + upd_cnt[1] + upd_cnt[2] == 0, "R6", upd_cnt[0], 0);
        cyc = 1'b1;
        tick(6);
        chk_out(w, "R9");
        cur_w = w;

        // R2: restaging only channel B leaves A and C with their old words.
        w = cur_w;
        w[1] = 15'h1234;
        load_ch(1, w[1]);
        cyc = 1'b0; tick(5); cyc = 1'b1; tick(6);
        chk_out(w, "R2");
        cur_w = w;

        // Sweep of computed words, including corner values.
        for (int k = 0; k < 40; k++) begin
            for (int c = 0; c < NCH; c++)
                w[c] = W'((k * 4663 + c * 12289 + 7 * k * c) & 32'h7FFF);
            if (k == 5)  begin w[0] = '1; w[1] = '1; w[2] = '1; end
            if (k == 6)  begin w[0] = '0; w[1] = '0; w[2] = '0; end
            if (k == 7)  begin w[0] = 15'h7FC0; w[1] = 15'h003F; w[2] = 15'h0040; end
            run_cycle(w);
        end

        // R8: reset mid-run clears both stages; a bare transfer yields zeros.
        rst_n = 1'b0;
        tick(3);
        for (int c = 0; c < NCH; c++) cur_w[c] = '0;
        chk_out(cur_w, "R8");
        rst_n = 1'b1;
        tick(3);
        cyc = 1'b0; tick(5); cyc = 1'b1; tick(6);
        chk_out(cur_w, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule